// File: doc/BRIEF.md
# Drive Status Packet Formatter

This block sits between a disc drive controller and the host processor that supervises it. It holds a working copy of the drive's report fields: a status byte, minute, second and frame bytes, and a one-nibble extension. On request it exports them as a nine-nibble status packet. A 4-bit checksum nibble completes the packet, so the host reads ten nibbles in all. When the report goes out, the block trims the drive control register and can raise a report-ready interrupt.

In the other direction the host hands over a command. A command consists of a code nibble and a query nibble. The block decodes the code into a one-cycle strobe that carries the effective operation and its argument. For table-of-contents queries it also writes the query result code into the low nibble of the working status byte. The environment supplies the drive's field values through a load port. The block does not model disc mechanics or timing.

Top module: `drv_status_fmt`

## Requirements
- R1: After reset, pktOut is all zero, csumOut is 0xF, drvCtrl is zero, and reportIrq, cmdValid and unknownCmd are low.
- R2: ldEn writes the working fields. Only expReq copies them into pktOut, in the cycle after the request edge. Nibble k occupies pktOut[4k+3:4k], in this order: status high, status low, minute high, minute low, second high, second low, frame high, frame low, extension.
- R3: csumOut equals the bitwise inverse of the 4-bit-truncated sum of the nine pktOut nibbles. It is valid in the same cycle that pktOut changes.
- R4: ctrlWr loads drvCtrl from ctrlIn. An export clears drvCtrl[7:2] and keeps drvCtrl[1:0]. When both occur at the same edge, the export takes effect.
- R5: An export makes reportIrq high for exactly one cycle when reportIrqEn is high at the request edge. When reportIrqEn is low, reportIrq stays low.
- R6: cmdWr captures cmdCode and cmdArg. In the following cycle, cmdValid pulses for one cycle if the code is a listed one. The listed codes are 0x0 status, 0x1 stop, 0x2 table-of-contents query, 0x3 read, 0x4 seek, 0x6 pause, 0x7 resume, 0x8 fast forward, 0x9 rewind, 0xA reset state, 0xC close tray and 0xD open tray. In that pulse, cmdOp is the code and cmdSub is the captured argument.
- R7: Codes 0x5, 0xB, 0xE and 0xF pulse unknownCmd instead of cmdValid. They leave the working fields unchanged.
- R8: Code 0x2 with an argument from 0 to 5 writes the argument into the status low nibble and keeps the high nibble. The change is visible at the next export. The strobe then shows cmdOp 0x2.
- R9: Code 0x2 with an argument above 5 writes 0xF into the status low nibble. The strobe then reports a plain status operation: cmdOp 0x0 and cmdSub 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldEn | input | 1 | Load working report fields |
| ldStatus | input | 8 | Status byte to load |
| ldMinute | input | 8 | Minute byte to load |
| ldSecond | input | 8 | Second byte to load |
| ldFrame | input | 8 | Frame byte to load |
| ldExt | input | 4 | Extension nibble to load |
| expReq | input | 1 | Export the working fields as a status packet |
| reportIrqEn | input | 1 | Host mask enable for the report-ready interrupt |
| ctrlWr | input | 1 | Write the drive control register |
| ctrlIn | input | 8 | Drive control write data |
| cmdWr | input | 1 | Command packet written by the host |
| cmdCode | input | 4 | Command code nibble |
| cmdArg | input | 4 | Command query nibble |
| pktOut | output | 36 | Exported status packet, nine nibbles |
| csumOut | output | 4 | Packet checksum nibble |
| drvCtrl | output | 8 | Drive control register |
| reportIrq | output | 1 | Report-ready interrupt request pulse |
| cmdValid | output | 1 | Decoded command strobe |
| cmdOp | output | 4 | Effective operation code |
| cmdSub | output | 4 | Operation argument or query result code |
| unknownCmd | output | 1 | Unlisted command code strobe |

## Verification
The working fields are exposed only through export. A corrupted working field, or a wrong table-of-contents write, therefore shows in pktOut and csumOut one cycle after the next expReq. A wrong checksum fold shows in csumOut in that same cycle. Decode errors show in the cycle after cmdWr as a wrong cmdOp or cmdSub, a missing strobe, or a strobe on the wrong one of cmdValid and unknownCmd. A stuck interrupt or control register shows one cycle after an export.

// File: rtl/drv_status_pkg.sv
package drv_status_pkg;
  localparam int NIB_W = 4;
  localparam int PKT_NIBS = 9;
  localparam int PKT_W = NIB_W * PKT_NIBS;

  typedef struct packed {
    logic load;
    logic exportPkt;
    logic ctrlWr;
    logic tocWr;
    logic [NIB_W-1:0] tocNib;
  } ctlStrobes_t;
endpackage

// File: rtl/drv_status_ctl.sv
module drv_status_ctl
  import drv_status_pkg::*;
#(
  parameter logic [15:0] KNOWN_CODES = 16'h37DF,
  parameter logic [NIB_W-1:0] TOC_CODE = 4'h2,
  parameter logic [NIB_W-1:0] TOC_LAST = 4'h5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ldEn,
  input  logic             expReq,
  input  logic             ctrlWr,
  input  logic             cmdWr,
  input  logic [NIB_W-1:0] cmdCode,
  input  logic [NIB_W-1:0] cmdArg,
  output ctlStrobes_t      ctl,
  output logic             cmdValid,
  output logic [NIB_W-1:0] cmdOp,
  output logic [NIB_W-1:0] cmdSub,
  output logic             unknownCmd
);
  localparam logic [NIB_W-1:0] BAD_QUERY = '1;
  localparam logic [NIB_W-1:0] STATUS_OP = '0;

  logic [NIB_W-1:0] codeReg, argReg;
  logic decodePend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg <= '0;
      argReg <= '0;
      decodePend <= 1'b0;
    end else begin
      decodePend <= cmdWr;
      if (cmdWr) begin
        codeReg <= cmdCode;
        argReg <= cmdArg;
      end
    end
  end

  logic isKnown, isToc, queryOk;
  always_comb begin
    isKnown = KNOWN_CODES[codeReg];
    isToc = (codeReg == TOC_CODE);
    queryOk = (argReg <= TOC_LAST);
    cmdValid = decodePend && isKnown;
    unknownCmd = decodePend && !isKnown;
    cmdOp = codeReg;
    cmdSub = argReg;
    if (isToc && !queryOk) begin
      cmdOp = STATUS_OP;
      cmdSub = BAD_QUERY;
    end
    ctl.load = ldEn;
    ctl.exportPkt = expReq;
    ctl.ctrlWr = ctrlWr;
    ctl.tocWr = decodePend && isToc;
    ctl.tocNib = queryOk ? argReg : BAD_QUERY;
  end

  a_r6_pulse_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid || unknownCmd) |-> $past(cmdWr));
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && unknownCmd));
  a_r9_query_code_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tocWr |-> (ctl.tocNib <= TOC_LAST || ctl.tocNib == BAD_QUERY));
endmodule

// File: rtl/drv_status_dp.sv
module drv_status_dp
  import drv_status_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int CTRL_KEEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [7:0]        ldStatus,
  input  logic [7:0]        ldMinute,
  input  logic [7:0]        ldSecond,
  input  logic [7:0]        ldFrame,
  input  logic [NIB_W-1:0]  ldExt,
  input  logic              reportIrqEn,
  input  logic [CTRL_W-1:0] ctrlIn,
  output logic [PKT_W-1:0]  pktOut,
  output logic [NIB_W-1:0]  csumOut,
  output logic [CTRL_W-1:0] drvCtrl,
  output logic              reportIrq
);
  localparam int SUM_W = NIB_W + $clog2(PKT_NIBS + 1);
  localparam logic [CTRL_W-1:0] KEEP_MASK = CTRL_W'((1 << CTRL_KEEP) - 1);

  logic [7:0] wSts, wMin, wSec, wFrm;
  logic [NIB_W-1:0] wExt;
  logic [PKT_W-1:0] pktReg, pktNext;

  always_comb
    pktNext = {wExt, wFrm[3:0], wFrm[7:4], wSec[3:0], wSec[7:4],
               wMin[3:0], wMin[7:4], wSts[3:0], wSts[7:4]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wSts <= '0; wMin <= '0; wSec <= '0; wFrm <= '0; wExt <= '0;
      pktReg <= '0;
      drvCtrl <= '0;
      reportIrq <= 1'b0;
    end else begin
      if (ctl.load) begin
        wSts <= ldStatus; wMin <= ldMinute; wSec <= ldSecond;
        wFrm <= ldFrame; wExt <= ldExt;
      end else if (ctl.tocWr) begin
        wSts[3:0] <= ctl.tocNib;
      end
      if (ctl.exportPkt) begin
        pktReg <= pktNext;
        drvCtrl <= drvCtrl & KEEP_MASK;
      end else if (ctl.ctrlWr) begin
        drvCtrl <= ctrlIn;
      end
      reportIrq <= ctl.exportPkt && reportIrqEn;
    end
  end

  logic [SUM_W-1:0] partSum [PKT_NIBS+1];
  assign partSum[0] = '0;
  for (genvar i = 0; i < PKT_NIBS; i++) begin : g_fold
    assign partSum[i+1] = partSum[i] + SUM_W'(pktReg[i*NIB_W +: NIB_W]);
  end

  assign csumOut = ~partSum[PKT_NIBS][NIB_W-1:0];
  assign pktOut = pktReg;

  a_r2_pkt_only_on_export: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.exportPkt) |-> $stable(pktOut));
  a_r4_ctrl_trimmed: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.exportPkt) |-> (drvCtrl & ~KEEP_MASK) == '0);
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    reportIrq |-> ($past(ctl.exportPkt) && $past(reportIrqEn)));
  a_r5_irq_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    reportIrq && !ctl.exportPkt |=> !reportIrq);
endmodule

// File: rtl/drv_status_fmt.sv
module drv_status_fmt
  import drv_status_pkg::*;
#(
  parameter logic [15:0] KNOWN_CODES = 16'h37DF,
  parameter int CTRL_KEEP = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ldEn,
  input  logic [7:0]  ldStatus,
  input  logic [7:0]  ldMinute,
  input  logic [7:0]  ldSecond,
  input  logic [7:0]  ldFrame,
  input  logic [3:0]  ldExt,
  input  logic        expReq,
  input  logic        reportIrqEn,
  input  logic        ctrlWr,
  input  logic [7:0]  ctrlIn,
  input  logic        cmdWr,
  input  logic [3:0]  cmdCode,
  input  logic [3:0]  cmdArg,
  output logic [35:0] pktOut,
  output logic [3:0]  csumOut,
  output logic [7:0]  drvCtrl,
  output logic        reportIrq,
  output logic        cmdValid,
  output logic [3:0]  cmdOp,
  output logic [3:0]  cmdSub,
  output logic        unknownCmd
);
  ctlStrobes_t ctl;

  drv_status_ctl #(.KNOWN_CODES(KNOWN_CODES)) u_ctl (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .expReq(expReq), .ctrlWr(ctrlWr),
    .cmdWr(cmdWr), .cmdCode(cmdCode), .cmdArg(cmdArg), .ctl(ctl),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdSub(cmdSub), .unknownCmd(unknownCmd)
  );

  drv_status_dp #(.CTRL_W(8), .CTRL_KEEP(CTRL_KEEP)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ldStatus(ldStatus), .ldMinute(ldMinute),
    .ldSecond(ldSecond), .ldFrame(ldFrame), .ldExt(ldExt),
    .reportIrqEn(reportIrqEn), .ctrlIn(ctrlIn), .pktOut(pktOut),
    .csumOut(csumOut), .drvCtrl(drvCtrl), .reportIrq(reportIrq)
  );
endmodule

// File: tb/tb_drv_status_fmt.sv
module tb_drv_status_fmt;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldEn = 0, expReq = 0, reportIrqEn = 0, ctrlWr = 0, cmdWr = 0;
  logic [7:0] ldStatus = 0, ldMinute = 0, ldSecond = 0, ldFrame = 0, ctrlIn = 0;
  logic [3:0] ldExt = 0, cmdCode = 0, cmdArg = 0;
  logic [35:0] pktOut;
  logic [3:0] csumOut, cmdOp, cmdSub;
  logic [7:0] drvCtrl;
  logic reportIrq, cmdValid, unknownCmd;
  int errs = 0, checks = 0;
  logic [7:0] mSts, mMin, mSec, mFrm;
  logic [3:0] mExt;

  always #5 clk = ~clk;

  drv_status_fmt dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] mkPkt();
    return {mExt, mFrm[3:0], mFrm[7:4], mSec[3:0], mSec[7:4],
            mMin[3:0], mMin[7:4], mSts[3:0], mSts[7:4]};
  endfunction

  function automatic logic [3:0] mkSum(logic [35:0] p);
    logic [3:0] s = 0;
    for (int i = 0; i < 9; i++) s += p[i*4 +: 4];
    return ~s;
  endfunction

  task automatic loadFields(logic [7:0] s, logic [7:0] m, logic [7:0] c, logic [7:0] f, logic [3:0] e);
    @(negedge clk);
    ldEn = 1; ldStatus = s; ldMinute = m; ldSecond = c; ldFrame = f; ldExt = e;
    @(negedge clk);
    ldEn = 0;
    mSts = s; mMin = m; mSec = c; mFrm = f; mExt = e;
  endtask

  task automatic doExport(logic en);
    @(negedge clk);
    expReq = 1; reportIrqEn = en;
    @(negedge clk);
    expReq = 0; reportIrqEn = 0;
  endtask

  task automatic doCmd(logic [3:0] code, logic [3:0] arg);
    @(negedge clk);
    cmdWr = 1; cmdCode = code; cmdArg = arg;
    @(negedge clk);
    cmdWr = 0;
  endtask

  task automatic testReset();
    chk("R1 pkt", pktOut, 0);
    chk("R1 csum", csumOut, 4'hF);
    chk("R1 ctrl", drvCtrl, 0);
    chk("R1 strobes", {reportIrq, cmdValid, unknownCmd}, 0);
  endtask

  task automatic testLoadExport();
    loadFields(8'h12, 8'h34, 8'h56, 8'h78, 4'h9);
    chk("R2 no export yet", pktOut, 0);
    doExport(0);
    chk("R2 layout", pktOut, mkPkt());
    chk("R3 checksum", csumOut, mkSum(mkPkt()));
    chk("R5 irq masked", reportIrq, 0);
    loadFields(8'hFF, 8'hEE, 8'hDD, 8'hCC, 4'hB);
    doExport(1);
    chk("R2 second pattern", pktOut, mkPkt());
    chk("R3 checksum wrap", csumOut, mkSum(mkPkt()));
    chk("R5 irq raised", reportIrq, 1);
    @(negedge clk);
    chk("R5 irq one cycle", reportIrq, 0);
  endtask

  task automatic testCtrl();
    @(negedge clk); ctrlWr = 1; ctrlIn = 8'hA7;
    @(negedge clk); ctrlWr = 0;
    chk("R4 ctrl write", drvCtrl, 8'hA7);
    doExport(0);
    chk("R4 ctrl trimmed", drvCtrl, 8'h03);
    @(negedge clk); ctrlWr = 1; ctrlIn = 8'hFE; expReq = 1;
    @(negedge clk); ctrlWr = 0; expReq = 0;
    chk("R4 export wins", drvCtrl, 8'h03);
  endtask

  task automatic testDecode();
    logic [3:0] known [12] = '{4'h0, 4'h1, 4'h3, 4'h4, 4'h6, 4'h7, 4'h8, 4'h9, 4'hA, 4'hC, 4'hD, 4'h0};
    for (int i = 0; i < 11; i++) begin
      doCmd(known[i], 4'h6);
      chk("R6 valid", {cmdValid, unknownCmd}, 2'b10);
      chk("R6 op", cmdOp, known[i]);
      chk("R6 sub", cmdSub, 4'h6);
      @(negedge clk);
      chk("R6 pulse ends", cmdValid, 0);
    end
  endtask

  task automatic testUnknown();
    logic [3:0] bad [4] = '{4'h5, 4'hB, 4'hE, 4'hF};
    loadFields(8'h41, 8'h02, 8'h03, 8'h04, 4'h5);
    for (int i = 0; i < 4; i++) begin
      doCmd(bad[i], 4'h1);
      chk("R7 unknown strobe", {cmdValid, unknownCmd}, 2'b01);
    end
    doExport(0);
    chk("R7 fields untouched", pktOut, mkPkt());
  endtask

  task automatic testToc();
    for (int q = 0; q < 6; q++) begin
      doCmd(4'h2, 4'(q));
      chk("R8 op", {cmdValid, cmdOp, cmdSub}, {1'b1, 4'h2, 4'(q)});
      doExport(0);
      mSts[3:0] = 4'(q);
      chk("R8 status low nibble", pktOut, mkPkt());
      chk("R8 checksum", csumOut, mkSum(mkPkt()));
    end
    doCmd(4'h2, 4'h9);
    chk("R9 fallback", {cmdValid, cmdOp, cmdSub}, {1'b1, 4'h0, 4'hF});
    doExport(0);
    mSts[3:0] = 4'hF;
    chk("R9 status low nibble", pktOut, mkPkt());
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1;
        @(negedge clk);
        testReset();
        testLoadExport();
        testCtrl();
        testDecode();
        testUnknown();
        testToc();
      end
      begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule